// File: doc/BRIEF.md
# TDM Channel Strobe Generator

This block generates the per-channel bus strobes for a device that drives a parallel bus on its own, in step with a serial TDM frame at 2048 kbit/s. The frame holds 32 slots of 8 bit cells each. The block runs on the bit clock and is realigned by a frame pulse. A mode pin selects whether all 32 slots are live or only 24 of them.

For every live slot the block drives two active-low strobes, each four bit cells long. The channel-start strobe covers the first half of the slot. The delayed chip-select strobe covers the second half. Two such generators can therefore share one parallel bus: the delayed strobe of the first generator can enable the second one. The block also presents the current slot number as a channel address, and holds it for the whole slot.

All pins are plain control and timing signals. There is no data stream at the edge of this block, so there is no handshake and no back-pressure. Until the first frame pulse arrives after reset, the counters free-run and both strobes stay high.

Top module: `tdm_strobe_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first frame pulse is sampled, `chan_start_n` and `dly_cs_n` are both high. `chan_addr` is 0 directly after reset.
- R2: When `frame_sync` is high at a rising clock edge, the next bit cell is bit 0 of slot 0. `chan_addr` reads 0 from that edge onward.
- R3: Without a frame pulse, `chan_addr` increments by one every 8 clocks and wraps from 31 to 0. It is held constant within a slot.
- R4: In a live slot, `chan_start_n` is low during bit cells 0 to 3 and high during bit cells 4 to 7.
- R5: In a live slot, `dly_cs_n` is low during bit cells 4 to 7 and high during bit cells 0 to 3.
- R6: With `mode32` = 1, all 32 slots are live. Once aligned, each frame shows 128 clocks of `chan_start_n` low.
- R7: With `mode32` = 0, slots whose `chan_addr[1:0]` equals 0 are dead and keep both strobes high. The other 24 slots are live, giving 96 clocks of `chan_start_n` low per frame.
- R8: `chan_start_n` and `dly_cs_n` are never low in the same clock.
- R9: A frame pulse that arrives in the middle of a frame realigns the counters to slot 0, bit 0 on the next clock.
- R10: A change on `mode32` takes effect on the strobes in the same bit cell, with no clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one rising edge per serial bit cell |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | Active-high frame alignment pulse, sampled on the clock |
| mode32 | input | 1 | 1 selects 32 live slots; 0 selects 24 live slots |
| chan_start_n | output | 1 | Active-low strobe over the first half of a live slot |
| dly_cs_n | output | 1 | Active-low strobe over the second half of a live slot |
| chan_addr | output | 5 | Number of the current slot |

## Verification
A wrong bit counter shows at the next half-slot boundary at the latest, because the strobes then toggle on the wrong clock. That is at most four clocks after the fault. A wrong slot counter shows at once on `chan_addr`. In 24-slot mode it also shows within one slot as strobes that fire in a dead slot or are missing from a live one. A lost alignment or lock flag shows as strobes present before the first frame pulse, or as `chan_addr` failing to return to 0 on the clock after a pulse. The bench predicts every output on every clock, so each of these faults is caught on the first cycle where it differs.

// File: rtl/tdm_strobe_pkg.sv
package tdm_strobe_pkg;
  localparam int unsigned BITS_PER_SLOT  = 8;
  localparam int unsigned SLOTS_PER_FRM  = 32;
  localparam int unsigned SPARSE_STRIDE  = 4;
  localparam int unsigned SLOT_W         = $clog2(SLOTS_PER_FRM);
  localparam int unsigned BIT_W          = $clog2(BITS_PER_SLOT);

  typedef enum logic {
    MODE_SPARSE24 = 1'b0,
    MODE_FULL32   = 1'b1
  } slot_mode_e;

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic [BIT_W-1:0]  bitc;
  } frame_pos_t;
endpackage

// File: rtl/tdm_bit_slot_counter.sv
module tdm_bit_slot_counter
  import tdm_strobe_pkg::*;
#(
  parameter int unsigned BITS  = BITS_PER_SLOT,
  parameter int unsigned SLOTS = SLOTS_PER_FRM,
  localparam int unsigned BW   = $clog2(BITS),
  localparam int unsigned SW   = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_sync,
  output logic [BW-1:0] bit_idx,
  output logic [SW-1:0] slot_idx,
  output logic          locked
);
  localparam logic [BW-1:0] LAST_BIT  = BW'(BITS - 1);
  localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

  logic slot_end;
  assign slot_end = (bit_idx == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_idx  <= '0;
      slot_idx <= '0;
      locked   <= 1'b0;
    end else if (frame_sync) begin
      bit_idx  <= '0;
      slot_idx <= '0;
      locked   <= 1'b1;
    end else if (slot_end) begin
      bit_idx  <= '0;
      slot_idx <= (slot_idx == LAST_SLOT) ? '0 : slot_idx + 1'b1;
    end else begin
      bit_idx  <= bit_idx + 1'b1;
    end
  end

  // R2 / R9: a frame pulse lands on slot 0, bit 0
  assert_frame_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (bit_idx == '0 && slot_idx == '0 && locked));

  // R3: the slot number only moves at a slot boundary
  assert_slot_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_sync && bit_idx != LAST_BIT) |=> $stable(slot_idx));

  // R3: wrap from the last slot back to zero
  assert_slot_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_sync && bit_idx == LAST_BIT && slot_idx == LAST_SLOT) |=> (slot_idx == '0));
endmodule

// File: rtl/tdm_slot_qualifier.sv
module tdm_slot_qualifier
  import tdm_strobe_pkg::*;
#(
  parameter int unsigned SLOTS  = SLOTS_PER_FRM,
  parameter int unsigned STRIDE = SPARSE_STRIDE,
  localparam int unsigned SW    = $clog2(SLOTS)
) (
  input  logic [SW-1:0] slot_idx,
  input  slot_mode_e    mode,
  output logic          slot_live
);
  logic [SLOTS-1:0] sparse_mask;

  for (genvar s = 0; s < SLOTS; s++) begin : g_mask
    assign sparse_mask[s] = ((s % STRIDE) != 0);
  end

  always_comb begin
    if (mode == MODE_FULL32) slot_live = 1'b1;
    else                     slot_live = sparse_mask[slot_idx];
  end
endmodule

// File: rtl/tdm_strobe_shaper.sv
module tdm_strobe_shaper
  import tdm_strobe_pkg::*;
#(
  parameter int unsigned BITS = BITS_PER_SLOT,
  localparam int unsigned BW  = $clog2(BITS),
  localparam logic [BW-1:0] HALF = BW'(BITS / 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] bit_idx,
  input  logic          slot_live,
  input  logic          locked,
  output logic          start_n,
  output logic          late_n
);
  logic active, first_half;

  assign active     = slot_live && locked && rst_n;
  assign first_half = (bit_idx < HALF);
  assign start_n    = !(active && first_half);
  assign late_n     = !(active && !first_half);

  // R8: the two half-slot strobes never overlap
  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!start_n && !late_n));

  // R4 / R5: the late strobe follows the start strobe without a gap
  assert_late_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(start_n) && bit_idx == HALF && slot_live) |-> !late_n);
endmodule

// File: rtl/tdm_strobe_gen.sv
module tdm_strobe_gen
  import tdm_strobe_pkg::*;
#(
  parameter int unsigned BITS   = BITS_PER_SLOT,
  parameter int unsigned SLOTS  = SLOTS_PER_FRM,
  parameter int unsigned STRIDE = SPARSE_STRIDE,
  localparam int unsigned BW    = $clog2(BITS),
  localparam int unsigned SW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_sync,
  input  logic          mode32,
  output logic          chan_start_n,
  output logic          dly_cs_n,
  output logic [SW-1:0] chan_addr
);
  logic [BW-1:0] bit_idx;
  logic [SW-1:0] slot_idx;
  logic          locked;
  logic          slot_live;
  slot_mode_e    mode;

  assign mode = mode32 ? MODE_FULL32 : MODE_SPARSE24;

  tdm_bit_slot_counter #(.BITS(BITS), .SLOTS(SLOTS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .bit_idx(bit_idx), .slot_idx(slot_idx), .locked(locked)
  );

  tdm_slot_qualifier #(.SLOTS(SLOTS), .STRIDE(STRIDE)) u_qual (
    .slot_idx(slot_idx), .mode(mode), .slot_live(slot_live)
  );

  tdm_strobe_shaper #(.BITS(BITS)) u_shape (
    .clk(clk), .rst_n(rst_n), .bit_idx(bit_idx), .slot_live(slot_live),
    .locked(locked), .start_n(chan_start_n), .late_n(dly_cs_n)
  );

  assign chan_addr = slot_idx;

  // R7: dead slots in 24-slot mode carry no strobe
  assert_dead_slot_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode32 && (chan_addr % STRIDE) == 0) |-> (chan_start_n && dly_cs_n));

  // R6: once aligned in 32-slot mode, exactly one strobe is low in every cell
  assert_full_mode_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode32 && locked) |-> (chan_start_n != dly_cs_n));

  // R1: nothing strobes before the first frame pulse
  assert_quiet_unlocked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (chan_start_n && dly_cs_n));
endmodule

// File: tb/tdm_strobe_gen_tb_top.sv
module tdm_strobe_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_sync = 1'b0;
  logic mode32 = 1'b1;
  logic chan_start_n, dly_cs_n;
  logic [4:0] chan_addr;

  int n_checks = 0;
  int n_fail = 0;
  int m_bit = 0, m_slot = 0, m_lock = 0;
  int low_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_strobe_gen dut_i (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .mode32(mode32),
    .chan_start_n(chan_start_n), .dly_cs_n(dly_cs_n), .chan_addr(chan_addr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, compared every clock
  always @(posedge clk) begin
    bit rs, fs, live, e_start, e_dly;
    rs = rst_n;
    fs = frame_sync;
    if (!rs) begin
      m_bit = 0; m_slot = 0; m_lock = 0;
    end else if (fs) begin
      m_bit = 0; m_slot = 0; m_lock = 1;
    end else begin
      m_bit++;
      if (m_bit == 8) begin
        m_bit = 0;
        m_slot = (m_slot + 1) % 32;
      end
    end
    #2;
    if (rst_n && !done) begin
      live    = (m_lock != 0) && (mode32 || (m_slot % 4) != 0);
      e_start = !(live && m_bit < 4);
      e_dly   = !(live && m_bit >= 4);
      check(int'(chan_addr) == m_slot, "R3 chan_addr", int'(chan_addr), m_slot);
      check(chan_start_n == e_start, mode32 ? "R4/R6 chan_start_n" : "R4/R7 chan_start_n",
            int'(chan_start_n), int'(e_start));
      check(dly_cs_n == e_dly, mode32 ? "R5/R6 dly_cs_n" : "R5/R7 dly_cs_n",
            int'(dly_cs_n), int'(e_dly));
      check(!(!chan_start_n && !dly_cs_n), "R8 overlap", int'({chan_start_n, dly_cs_n}), 1);
      if (!chan_start_n) low_cnt++;
    end
  end

  task automatic pulse_and_count(output int cnt);
    @(negedge clk);
    frame_sync = 1'b1;
    low_cnt = 0;
    @(negedge clk);
    frame_sync = 1'b0;
    repeat (255) @(negedge clk);
    cnt = low_cnt;
  endtask

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    check(chan_start_n && dly_cs_n, "R1 strobes in reset", int'({chan_start_n, dly_cs_n}), 3);
    rst_n = 1'b1;
    @(negedge clk);
    check(chan_addr == 5'd0, "R1 addr after reset", int'(chan_addr), 0);
    repeat (20) @(negedge clk);
    check(chan_start_n && dly_cs_n, "R1 quiet before pulse", int'({chan_start_n, dly_cs_n}), 3);

    // R2: alignment on a pulse
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
    check(chan_addr == 5'd0 && !chan_start_n, "R2 slot0 bit0",
          int'({chan_addr, chan_start_n}), 0);

    mode32 = 1'b1;
    pulse_and_count(cnt);
    check(cnt == 128, "R6 live cells per frame", cnt, 128);

    mode32 = 1'b0;
    pulse_and_count(cnt);
    check(cnt == 96, "R7 live cells per frame", cnt, 96);

    // R9: mid-frame realignment
    repeat (100) @(negedge clk);
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
    check(chan_addr == 5'd0, "R9 realign addr", int'(chan_addr), 0);

    // R3: free-run across a wrap
    repeat (300) @(negedge clk);
    check(chan_addr == 5'd5, "R3 wrap position", int'(chan_addr), 5);

    // R10: immediate mode effect in a dead slot
    while (chan_addr != 5'd8) @(negedge clk);
    check(chan_start_n && dly_cs_n, "R7 dead slot 8", int'({chan_start_n, dly_cs_n}), 3);
    mode32 = 1'b1;
    #1;
    check(chan_start_n != dly_cs_n, "R10 mode applies at once",
          int'({chan_start_n, dly_cs_n}), 1);
    repeat (64) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule